// File: doc/BRIEF.md
# Dual-Modulus PLL Divider Chain

This block is the digital counting section of a frequency synthesizer. A feedback divider models a 64/65 dual-modulus prescaler steered by a 6-bit swallow count A and a 9-bit programmable count N. Together they divide the VCO-side event stream by 64·N + A. A 9-bit reference divider brings the reference event stream down to the phase-comparison rate. A separate 8-bit tuning divider produces a slow tuning clock from the same reference stream, for example 200 kHz. A lock flag compares the timing of the feedback and reference terminal counts.

Everything runs on one system clock. The VCO-side and reference inputs are one-cycle enables (`vco_ce`, `ref_ce`). Each divider gives a one-cycle terminal-count pulse in the same cycle as the enable that completes a period. It also gives a square-ish output that is high during the second half of the period. Divide values are plain inputs fed from a register block. A divider that is running picks up new values only at its own terminal count. Illegal values park the affected divider and raise a configuration-error flag. A power-down input parks all three dividers and forces the lock flag high.

Named states and transitions:
- Feedback divider: `SW_HOLD`, `SW_SWALLOW` (prescaler at 65), `SW_NORMAL` (prescaler at 64).
  - Load: from `SW_HOLD` to `SW_SWALLOW`, or to `SW_NORMAL` when A = 0.
  - Swallow done: from `SW_SWALLOW` to `SW_NORMAL` after A prescaler outputs.
  - Period end: back to the first phase, or to `SW_HOLD` when the new values are illegal.
  - Park: to `SW_HOLD` on power-down.
- Ratio dividers: `RD_HOLD` and `RD_RUN`, with the same load, period-end and park transitions.
- Lock detector: `LK_IDLE`, `LK_REF_FIRST`, `LK_MAIN_FIRST`.
  - Open: a lone edge moves `LK_IDLE` to the matching wait state.
  - Match: the other edge returns to `LK_IDLE` and counts as a hit.
  - Timeout: the wait runs out, returns to `LK_IDLE` and counts as a miss.

Top module: `pll_divider_chain`

## Requirements
- R1: While running with values N and A, `main_tc` pulses for exactly one cycle, together with the `vco_ce` that completes each group of 64·N + A enables. The pulse occurs only in a cycle where `vco_ce` is high.
- R2: Within a feedback period, the first A prescaler outputs each take 65 enables and the remaining N − A each take 64.
- R3: Feedback values are legal when 4032 ≤ 64·N + A ≤ 32767 and A ≤ N. Otherwise the feedback divider parks with `main_tc` and `main_out` low.
- R4: The reference divider pulses `ref_tc` on every R-th `ref_ce`, only in a cycle where `ref_ce` is high. R below 4 parks it.
- R5: The tuning divider pulses `tune_tc` on every F-th `ref_ce`, only in a cycle where `ref_ce` is high. F below 6 parks it.
- R6: `cfg_err` is high in the cycle after any clock edge at which any of the N/A, R or F inputs is illegal, and low otherwise.
- R7: `lock` goes high after 4 consecutive hits. A hit is a `main_tc` and a `ref_tc` no more than `lock_win` cycles apart; with `lock_win` = 0, only coincident edges count.
- R8: A single miss drops `lock`. A miss is a first edge whose partner does not arrive within `lock_win` cycles.
- R9: While `pwr_down` is high, `lock` reads 1 and no divider pulses. After release, the dividers reload and the hit count restarts from zero.
- R10: A value written while a divider is running takes effect only after that divider's next terminal count, so the period in progress keeps its old length.
- R11: `main_out` is high once floor(N/2) prescaler outputs of the period have occurred. `ref_out` and `tune_out` are high once floor(div/2) enables of the period have been counted.
- R12: During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Parks all dividers, forces lock high |
| vco_ce | input | 1 | One-cycle VCO-side input event |
| ref_ce | input | 1 | One-cycle reference input event |
| main_n | input | 9 | Programmable count N |
| main_a | input | 6 | Swallow count A |
| ref_div | input | 9 | Reference divide value R |
| tune_div | input | 8 | Tuning divide value F |
| lock_win | input | 8 | Lock coincidence window in clocks |
| main_tc | output | 1 | Feedback terminal-count pulse |
| main_out | output | 1 | Feedback half-period output |
| ref_tc | output | 1 | Reference terminal-count pulse |
| ref_out | output | 1 | Reference half-period output |
| tune_tc | output | 1 | Tuning terminal-count pulse |
| tune_out | output | 1 | Tuning half-period output |
| cfg_err | output | 1 | Registered illegal-setting flag |
| lock | output | 1 | Lock indication |

## Verification
The bench builds the block with its default parameters: a 9/6-bit feedback divider, a 9-bit reference divider, an 8-bit tuning divider, an 8-bit window and a four-hit lock count.

These values keep every feedback period at 4032 enables or more, so lock, drift and loss of lock all fit in about a hundred thousand cycles. It pairs N = 63 with a reference of 504 on one enable in eight so that the two edges line up. A = N = 63 is the all-swallow corner, and it is run with a half-rate VCO-side enable.

An 8-bit window lets a 200-cycle tolerance show a gradual drift out of lock. The minimum legal values sit one step from the illegal ones (N = 62 with A = 63, R = 3, F = 5), which brings every parking path within reach.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

    typedef enum logic [1:0] {
        SW_HOLD,
        SW_SWALLOW,
        SW_NORMAL
    } swallow_state_e;

    typedef enum logic {
        RD_HOLD,
        RD_RUN
    } ratio_state_e;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_REF_FIRST,
        LK_MAIN_FIRST
    } lock_state_e;

endpackage

// File: rtl/pll_ratio_div.sv
module pll_ratio_div
    import pll_div_pkg::*;
#(
    parameter int W       = 9,
    parameter int MIN_DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_i,
    input  logic         ce_i,
    input  logic [W-1:0] div_i,
    output logic         tc_o,
    output logic         out_o,
    output logic         bad_o
);

    localparam logic [W-1:0] MIN_V = W'(MIN_DIV);
    localparam logic [W-1:0] ONE_V = W'(1);

    ratio_state_e state;
    logic [W-1:0] div_act;
    logic [W-1:0] cnt;
    logic         wrap;

    assign bad_o = (div_i < MIN_V);
    assign wrap  = ce_i && (cnt == div_act - ONE_V);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= RD_HOLD;
            div_act <= '0;
            cnt     <= '0;
        end else begin
            unique case (state)
                RD_HOLD: begin
                    if (!hold_i && !bad_o) begin
                        div_act <= div_i;
                        cnt     <= '0;
                        state   <= RD_RUN;
                    end
                end
                RD_RUN: begin
                    if (hold_i) begin
                        state <= RD_HOLD;
                    end else if (wrap) begin
                        cnt <= '0;
                        if (bad_o) begin
                            state <= RD_HOLD;
                        end else begin
                            div_act <= div_i;
                        end
                    end else if (ce_i) begin
                        cnt <= cnt + ONE_V;
                    end
                end
                default: state <= RD_HOLD;
            endcase
        end
    end

    // outputs
    always_comb begin
        tc_o  = 1'b0;
        out_o = 1'b0;
        unique case (state)
            RD_HOLD: begin
                tc_o  = 1'b0;
                out_o = 1'b0;
            end
            RD_RUN: begin
                tc_o  = wrap;
                out_o = (cnt >= (div_act >> 1));
            end
            default: begin
                tc_o  = 1'b0;
                out_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pll_swallow_div.sv
module pll_swallow_div
    import pll_div_pkg::*;
#(
    parameter int NW       = 9,
    parameter int AW       = 6,
    parameter int MAIN_MIN = 4032,
    parameter int MAIN_MAX = 32767
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_i,
    input  logic          ce_i,
    input  logic [NW-1:0] n_i,
    input  logic [AW-1:0] a_i,
    output logic          tc_o,
    output logic          out_o,
    output logic          bad_o
);

    // prescaler low modulus is 2^AW (64), high modulus 2^AW+1 (65)
    localparam int LOW_MOD = 1 << AW;
    localparam int PW      = AW + 1;
    localparam int DW      = NW + AW + 1;
    localparam logic [PW-1:0] LAST_HI = PW'(LOW_MOD);
    localparam logic [PW-1:0] LAST_LO = PW'(LOW_MOD - 1);
    localparam logic [PW-1:0] PONE    = PW'(1);
    localparam logic [NW-1:0] NONE    = NW'(1);
    localparam logic [DW-1:0] MIN_V   = DW'(MAIN_MIN);
    localparam logic [DW-1:0] MAX_V   = DW'(MAIN_MAX);

    swallow_state_e state;
    logic [NW-1:0]  n_act;
    logic [AW-1:0]  a_act;
    logic [PW-1:0]  pre_cnt;
    logic [NW-1:0]  prog_cnt;
    logic [NW-1:0]  prog_nxt;
    logic [PW-1:0]  pre_last;
    logic           pre_wrap;
    logic           period_end;
    logic [DW-1:0]  div_val;

    // with a power-of-two low modulus, 64*N + A is the concatenation
    assign div_val    = {1'b0, n_i, a_i};
    assign bad_o      = (div_val < MIN_V) || (div_val > MAX_V) || (NW'(a_i) > n_i);
    assign pre_last   = (state == SW_SWALLOW) ? LAST_HI : LAST_LO;
    assign pre_wrap   = ce_i && (pre_cnt == pre_last);
    assign period_end = pre_wrap && (prog_cnt == n_act - NONE);
    assign prog_nxt   = prog_cnt + NONE;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= SW_HOLD;
            n_act    <= '0;
            a_act    <= '0;
            pre_cnt  <= '0;
            prog_cnt <= '0;
        end else begin
            unique case (state)
                SW_HOLD: begin
                    if (!hold_i && !bad_o) begin
                        n_act    <= n_i;
                        a_act    <= a_i;
                        pre_cnt  <= '0;
                        prog_cnt <= '0;
                        state    <= (a_i == '0) ? SW_NORMAL : SW_SWALLOW;
                    end
                end
                SW_SWALLOW, SW_NORMAL: begin
                    if (hold_i) begin
                        state <= SW_HOLD;
                    end else if (period_end) begin
                        pre_cnt  <= '0;
                        prog_cnt <= '0;
                        if (bad_o) begin
                            state <= SW_HOLD;
                        end else begin
                            n_act <= n_i;
                            a_act <= a_i;
                            state <= (a_i == '0) ? SW_NORMAL : SW_SWALLOW;
                        end
                    end else if (pre_wrap) begin
                        pre_cnt  <= '0;
                        prog_cnt <= prog_nxt;
                        if ((state == SW_SWALLOW) && (prog_nxt == NW'(a_act))) begin
                            state <= SW_NORMAL;
                        end
                    end else if (ce_i) begin
                        pre_cnt <= pre_cnt + PONE;
                    end
                end
                default: state <= SW_HOLD;
            endcase
        end
    end

    // outputs
    always_comb begin
        tc_o  = 1'b0;
        out_o = 1'b0;
        unique case (state)
            SW_HOLD: begin
                tc_o  = 1'b0;
                out_o = 1'b0;
            end
            SW_SWALLOW, SW_NORMAL: begin
                tc_o  = period_end;
                out_o = (prog_cnt >= (n_act >> 1));
            end
            default: begin
                tc_o  = 1'b0;
                out_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import pll_div_pkg::*;
#(
    parameter int WINW = 8,
    parameter int HITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_down_i,
    input  logic            main_tc_i,
    input  logic            ref_tc_i,
    input  logic [WINW-1:0] win_i,
    output logic            lock_o
);

    localparam int SW = $clog2(HITS + 1);
    localparam logic [SW-1:0]   HITS_V = SW'(HITS);
    localparam logic [SW-1:0]   SONE   = SW'(1);
    localparam logic [WINW:0]   WONE   = (WINW + 1)'(1);

    lock_state_e     state;
    lock_state_e     state_nxt;
    logic [WINW-1:0] wcnt;
    logic [WINW-1:0] wcnt_nxt;
    logic [WINW:0]   wsum;
    logic [SW-1:0]   streak;
    logic            hit;
    logic            miss;
    logic            expired;

    assign wsum    = {1'b0, wcnt} + WONE;
    assign expired = (wsum >= {1'b0, win_i});

    // transitions
    always_comb begin
        state_nxt = state;
        wcnt_nxt  = wcnt;
        hit       = 1'b0;
        miss      = 1'b0;
        unique case (state)
            LK_IDLE: begin
                if (main_tc_i && ref_tc_i) begin
                    hit = 1'b1;
                end else if (ref_tc_i || main_tc_i) begin
                    if (win_i == '0) begin
                        miss = 1'b1;
                    end else begin
                        state_nxt = ref_tc_i ? LK_REF_FIRST : LK_MAIN_FIRST;
                        wcnt_nxt  = '0;
                    end
                end
            end
            LK_REF_FIRST: begin
                if (main_tc_i) begin
                    hit       = 1'b1;
                    state_nxt = LK_IDLE;
                end else if (expired) begin
                    miss      = 1'b1;
                    state_nxt = LK_IDLE;
                end else begin
                    wcnt_nxt = wsum[WINW-1:0];
                end
            end
            LK_MAIN_FIRST: begin
                if (ref_tc_i) begin
                    hit       = 1'b1;
                    state_nxt = LK_IDLE;
                end else if (expired) begin
                    miss      = 1'b1;
                    state_nxt = LK_IDLE;
                end else begin
                    wcnt_nxt = wsum[WINW-1:0];
                end
            end
            default: state_nxt = LK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= LK_IDLE;
            wcnt   <= '0;
            streak <= '0;
        end else if (pwr_down_i) begin
            state  <= LK_IDLE;
            wcnt   <= '0;
            streak <= '0;
        end else begin
            state <= state_nxt;
            wcnt  <= wcnt_nxt;
            if (hit) begin
                streak <= (streak == HITS_V) ? streak : streak + SONE;
            end else if (miss) begin
                streak <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        lock_o = pwr_down_i || (streak == HITS_V);
    end

endmodule

// File: rtl/pll_divider_chain.sv
module pll_divider_chain #(
    parameter int NW        = 9,
    parameter int AW        = 6,
    parameter int RW        = 9,
    parameter int FW        = 8,
    parameter int WINW      = 8,
    parameter int LOCK_HITS = 4,
    parameter int MAIN_MIN  = 4032,
    parameter int MAIN_MAX  = 32767,
    parameter int REF_MIN   = 4,
    parameter int TUNE_MIN  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_down,
    input  logic            vco_ce,
    input  logic            ref_ce,
    input  logic [NW-1:0]   main_n,
    input  logic [AW-1:0]   main_a,
    input  logic [RW-1:0]   ref_div,
    input  logic [FW-1:0]   tune_div,
    input  logic [WINW-1:0] lock_win,
    output logic            main_tc,
    output logic            main_out,
    output logic            ref_tc,
    output logic            ref_out,
    output logic            tune_tc,
    output logic            tune_out,
    output logic            cfg_err,
    output logic            lock
);

    logic main_bad;
    logic ref_bad;
    logic tune_bad;
    logic err_q;

    pll_swallow_div #(
        .NW       (NW),
        .AW       (AW),
        .MAIN_MIN (MAIN_MIN),
        .MAIN_MAX (MAIN_MAX)
    ) u_main (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (pwr_down),
        .ce_i   (vco_ce),
        .n_i    (main_n),
        .a_i    (main_a),
        .tc_o   (main_tc),
        .out_o  (main_out),
        .bad_o  (main_bad)
    );

    pll_ratio_div #(
        .W       (RW),
        .MIN_DIV (REF_MIN)
    ) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (pwr_down),
        .ce_i   (ref_ce),
        .div_i  (ref_div),
        .tc_o   (ref_tc),
        .out_o  (ref_out),
        .bad_o  (ref_bad)
    );

    pll_ratio_div #(
        .W       (FW),
        .MIN_DIV (TUNE_MIN)
    ) u_tune (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (pwr_down),
        .ce_i   (ref_ce),
        .div_i  (tune_div),
        .tc_o   (tune_tc),
        .out_o  (tune_out),
        .bad_o  (tune_bad)
    );

    pll_lock_detect #(
        .WINW (WINW),
        .HITS (LOCK_HITS)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down_i (pwr_down),
        .main_tc_i  (main_tc),
        .ref_tc_i   (ref_tc),
        .win_i      (lock_win),
        .lock_o     (lock)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= main_bad || ref_bad || tune_bad;
        end
    end

    assign cfg_err = err_q;

endmodule

// File: rtl/pll_divider_chain_chk.sv
module pll_divider_chain_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_down,
    input logic vco_ce,
    input logic ref_ce,
    input logic main_tc,
    input logic ref_tc,
    input logic tune_tc,
    input logic lock
);

    // R1
    main_tc_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_tc |-> vco_ce);

    // R1
    main_tc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_tc |=> !main_tc);

    // R4
    ref_tc_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tc |-> ref_ce);

    // R5
    tune_tc_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tune_tc |-> ref_ce);

    // R9
    pwr_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !(main_tc || ref_tc || tune_tc));

    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock) && !pwr_down && !$past(pwr_down)) |-> $past(main_tc || ref_tc));

endmodule

bind pll_divider_chain pll_divider_chain_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .vco_ce   (vco_ce),
    .ref_ce   (ref_ce),
    .main_tc  (main_tc),
    .ref_tc   (ref_tc),
    .tune_tc  (tune_tc),
    .lock     (lock)
);

// File: tb/pll_divider_chain_bench.sv
module pll_divider_chain_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic       vco_ce = 1'b0;
    logic       ref_ce = 1'b0;
    logic [8:0] main_n = 9'd63;
    logic [5:0] main_a = 6'd0;
    logic [8:0] ref_div = 9'd504;
    logic [7:0] tune_div = 8'd200;
    logic [7:0] lock_win = 8'd200;
    logic main_tc, main_out, ref_tc, ref_out, tune_tc, tune_out, cfg_err, lock;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // stimulus pacing
    int vco_every = 1;
    int ref_every = 8;
    int ce_phase = 0;

    // reference model state
    int cyc = 0;
    bit m_run = 0; int m_n = 0, m_a = 0, m_p = 0;
    bit r_run = 0; int r_d = 0, r_p = 0;
    bit t_run = 0; int t_d = 0, t_p = 0;
    bit err_exp = 0;
    int lk_pend = 0, lk_t0 = 0, lk_streak = 0;

    // observation
    int m_last = -1;
    int main_iv[$];
    int n_main = 0, n_ref = 0, n_tune = 0;
    bit lock_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_divider_chain u_pll_divider_chain (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .vco_ce(vco_ce), .ref_ce(ref_ce),
        .main_n(main_n), .main_a(main_a), .ref_div(ref_div), .tune_div(tune_div),
        .lock_win(lock_win), .main_tc(main_tc), .main_out(main_out), .ref_tc(ref_tc),
        .ref_out(ref_out), .tune_tc(tune_tc), .tune_out(tune_out), .cfg_err(cfg_err),
        .lock(lock)
    );

    function automatic bit main_ok(int n, int a);
        int d = 64 * n + a;
        return (d >= 4032) && (d <= 32767) && (a <= n);
    endfunction

    // prescaler outputs completed after p enables of a period
    function automatic int pulses_done(int p, int a);
        if (p < 65 * a) return p / 65;
        return a + (p - 65 * a) / 64;
    endfunction

    function automatic bit exp_mtc();
        return m_run && vco_ce && (m_p == 64 * m_n + m_a - 1);
    endfunction
    function automatic bit exp_rtc();
        return r_run && ref_ce && (r_p == r_d - 1);
    endfunction
    function automatic bit exp_ttc();
        return t_run && ref_ce && (t_p == t_d - 1);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // model update, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; r_run = 0; t_run = 0; err_exp = 0;
            lk_pend = 0; lk_streak = 0;
        end else begin
            bit e_m, e_r, e_t, hit, miss;
            int n_in, a_in, r_in, f_in;
            e_m = exp_mtc(); e_r = exp_rtc(); e_t = exp_ttc();
            n_in = int'(main_n); a_in = int'(main_a);
            r_in = int'(ref_div); f_in = int'(tune_div);
            // feedback divider
            if (!m_run) begin
                if (!pwr_down && main_ok(n_in, a_in)) begin
                    m_run = 1; m_n = n_in; m_a = a_in; m_p = 0;
                end
            end else if (pwr_down) m_run = 0;
            else if (e_m) begin
                m_p = 0;
                if (main_ok(n_in, a_in)) begin m_n = n_in; m_a = a_in; end
                else m_run = 0;
            end else if (vco_ce) m_p++;
            // reference divider
            if (!r_run) begin
                if (!pwr_down && r_in >= 4) begin r_run = 1; r_d = r_in; r_p = 0; end
            end else if (pwr_down) r_run = 0;
            else if (e_r) begin
                r_p = 0;
                if (r_in >= 4) r_d = r_in; else r_run = 0;
            end else if (ref_ce) r_p++;
            // tuning divider
            if (!t_run) begin
                if (!pwr_down && f_in >= 6) begin t_run = 1; t_d = f_in; t_p = 0; end
            end else if (pwr_down) t_run = 0;
            else if (e_t) begin
                t_p = 0;
                if (f_in >= 6) t_d = f_in; else t_run = 0;
            end else if (ref_ce) t_p++;
            err_exp = !main_ok(n_in, a_in) || (r_in < 4) || (f_in < 6);
            // lock: edges within lock_win clocks, four in a row
            if (pwr_down) begin
                lk_pend = 0; lk_streak = 0;
            end else begin
                hit = 0; miss = 0;
                case (lk_pend)
                    0: begin
                        if (e_m && e_r) hit = 1;
                        else if (e_m || e_r) begin
                            if (lock_win == 0) miss = 1;
                            else begin lk_pend = e_r ? 1 : 2; lk_t0 = cyc; end
                        end
                    end
                    1: begin
                        if (e_m) begin hit = 1; lk_pend = 0; end
                        else if (cyc - lk_t0 >= int'(lock_win)) begin miss = 1; lk_pend = 0; end
                    end
                    default: begin
                        if (e_r) begin hit = 1; lk_pend = 0; end
                        else if (cyc - lk_t0 >= int'(lock_win)) begin miss = 1; lk_pend = 0; end
                    end
                endcase
                if (hit) lk_streak = (lk_streak == 4) ? 4 : lk_streak + 1;
                else if (miss) lk_streak = 0;
            end
        end
        cyc++;
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            bit e_lock;
            check("R1", "main_tc", int'(main_tc), int'(exp_mtc()));
            check("R11", "main_out", int'(main_out),
                  int'(m_run && (pulses_done(m_p, m_a) >= m_n / 2)));
            check("R4", "ref_tc", int'(ref_tc), int'(exp_rtc()));
            check("R11", "ref_out", int'(ref_out), int'(r_run && (r_p >= r_d / 2)));
            check("R5", "tune_tc", int'(tune_tc), int'(exp_ttc()));
            check("R11", "tune_out", int'(tune_out), int'(t_run && (t_p >= t_d / 2)));
            check("R6", "cfg_err", int'(cfg_err), int'(err_exp));
            e_lock = pwr_down || (lk_streak == 4);
            check("R7", "lock", int'(lock), int'(e_lock));
            if (main_tc) begin
                if (m_last >= 0) main_iv.push_back(cyc - m_last);
                m_last = cyc;
                n_main++;
            end
            if (ref_tc) n_ref++;
            if (tune_tc) n_tune++;
            if (lock && !pwr_down) lock_seen = 1;
        end
    end

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            vco_ce = (vco_every == 1) ? 1'b1 : ((ce_phase % vco_every) == 0);
            ref_ce = ((ce_phase % ref_every) == 0);
            ce_phase++;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int base_m, base_r, base_t;
        // R12: reset state
        repeat (3) @(negedge clk);
        check("R12", "outputs in reset",
              int'({main_tc, main_out, ref_tc, ref_out, tune_tc, tune_out, cfg_err, lock}), 0);
        #1 rst_n = 1'b1;

        // R7: aligned periods 4032 / 504*8, lock should be gained
        run_cycles(25000);
        check("R7", "lock gained", int'(lock_seen), 1);
        check("R7", "lock high", int'(lock), 1);
        check("R1", "main period 64N+A", main_iv[main_iv.size()-1], 4032);

        // R10 and R8: lengthen N mid-period, drift out of lock
        main_iv.delete();
        main_n = 9'd64;
        run_cycles(24000);
        check("R10", "period in progress keeps old length", main_iv[0], 4032);
        check("R10", "next period uses new value", main_iv[1], 4096);
        check("R8", "lock lost after miss", int'(lock), 0);

        // R2: all-swallow corner at half-rate enables
        main_n = 9'd63; main_a = 6'd63; vco_every = 2;
        run_cycles(9000);
        main_iv.delete();
        run_cycles(21000);
        check("R2", "A=N=63 period in clocks", main_iv[1], 2 * 4095);

        // R4, R5, R6: illegal reference and tuning values park their dividers
        ref_div = 9'd3; tune_div = 8'd5;
        run_cycles(2);
        check("R6", "cfg_err raised", int'(cfg_err), 1);
        run_cycles(6000);
        base_r = n_ref; base_t = n_tune;
        run_cycles(4000);
        check("R4", "no ref_tc while R=3", n_ref - base_r, 0);
        check("R5", "no tune_tc while F=5", n_tune - base_t, 0);
        ref_div = 9'd504; tune_div = 8'd200;
        run_cycles(2);
        check("R6", "cfg_err cleared", int'(cfg_err), 0);

        // R3: 64*62+63 = 4031 is below range, feedback parks
        vco_every = 1;
        main_n = 9'd62; main_a = 6'd63;
        run_cycles(9000);
        base_m = n_main;
        run_cycles(4000);
        check("R3", "no main_tc while illegal", n_main - base_m, 0);
        check("R3", "main_out low while parked", int'(main_out), 0);

        // R9: power-down
        main_n = 9'd63; main_a = 6'd0;
        run_cycles(3000);
        pwr_down = 1'b1;
        run_cycles(2);
        base_m = n_main; base_r = n_ref; base_t = n_tune;
        run_cycles(200);
        check("R9", "lock high in power-down", int'(lock), 1);
        check("R9", "no pulses in power-down", (n_main - base_m) + (n_ref - base_r) + (n_tune - base_t), 0);
        pwr_down = 1'b0;
        run_cycles(2);
        check("R9", "lock restarts low", int'(lock), 0);
        base_m = n_main;
        run_cycles(5000);
        check("R9", "feedback resumes after release", int'(n_main > base_m), 1);

        finish_run();
    end

endmodule